// File: doc/BRIEF.md
# Predicate Register File with Paired Compare

This block holds the 1-bit condition flags of one execution cluster and the compare logic that sets them. Each compare slot evaluates an integer relation between two operands and writes a pair of flags in one step: the even flag of the pair receives the relation result and the odd flag receives its inverse. A compare may name a guard flag, which is ANDed into both written values. An if/else nested inside another condition thus becomes plain data flow, with no branch.

Each issued operation names one flag through a query port. The block answers with a commit enable, which is high only when the operation is valid and its flag is set. Flag 0 always reads as set, so an operation or compare that needs no condition names index 0. Writes land at the clock edge. Every read in the same cycle, guard reads included, sees the value from before that edge.

Top module: `pred_file_top`

## Requirements
- R1: During and after reset, every flag reads 0 except flag 0, so `pred_vec` equals 16'h0001 with the default parameters.
- R2: Flag 0 reads 1 at all times and ignores every write, including one from a compare whose pair index is 0.
- R3: The 3-bit relation code selects one of: 0 equal, 1 not equal, 2 signed less-than, 3 signed less-or-equal, 4 signed greater-than, 5 signed greater-or-equal, 6 unsigned less-than, 7 unsigned greater-or-equal.
- R4: A valid compare with pair index p writes the relation result to flag 2p and its inverse to flag 2p+1.
- R5: The guard flag is ANDed into both written values. When the guard reads 0, both flags of the pair are written 0. Guard index 0 leaves the compare unguarded.
- R6: A write is visible from the cycle after the compare. A query or guard read in the compare's own cycle returns the old value.
- R7: When two compare slots write the same flag in one cycle, the value from the higher-numbered slot is stored.
- R8: Each query output `qry_commit[k]` is high only when `qry_valid[k]` is high and the flag at `qry_idx[k]` reads 1.
- R9: A slot whose `cmp_valid` bit is low changes no flag, whatever its other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cmp_valid | input | NUM_SLOTS | Compare issued in each slot |
| cmp_op | input | NUM_SLOTS x 3 | Relation code per slot |
| cmp_src_a | input | NUM_SLOTS x DATA_W | First operand per slot |
| cmp_src_b | input | NUM_SLOTS x DATA_W | Second operand per slot |
| cmp_pair | input | NUM_SLOTS x (log2(NUM_PREDS)-1) | Destination pair index per slot |
| cmp_guard | input | NUM_SLOTS x log2(NUM_PREDS) | Guard flag index per slot |
| qry_valid | input | NUM_QUERY | Operation present on each query port |
| qry_idx | input | NUM_QUERY x log2(NUM_PREDS) | Flag named by each operation |
| qry_commit | output | NUM_QUERY | Commit enable per query port |
| pred_vec | output | NUM_PREDS | Current value of every flag |

## Verification
The assertions assume that the flag count is a power of two, so that every pair and guard index names a real flag, and that inputs are never unknown after reset. The bench drives every input to a known value from time zero. It draws indices over their full ranges and operands from a pool that includes equal values and the signed/unsigned extremes. The pair-complement and guard properties are checked only for the highest slot, because that slot's writes are the ones stored when slots collide. The stimulus makes collisions often, so that lower-slot writes are overridden.

// File: rtl/pred_pkg.sv
package pred_pkg;

    typedef enum logic [2:0] {
        REL_EQ  = 3'd0,
        REL_NE  = 3'd1,
        REL_SLT = 3'd2,
        REL_SLE = 3'd3,
        REL_SGT = 3'd4,
        REL_SGE = 3'd5,
        REL_ULT = 3'd6,
        REL_UGE = 3'd7
    } rel_e;

endpackage

// File: rtl/pred_rel_eval.sv
module pred_rel_eval #(
    parameter int DATA_W = 32
) (
    input  pred_pkg::rel_e    rel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              hit
);
    logic eq_w;
    logic slt_w;
    logic ult_w;

    assign eq_w  = (opnd_a == opnd_b);
    assign slt_w = ($signed(opnd_a) < $signed(opnd_b));
    assign ult_w = (opnd_a < opnd_b);

    always_comb begin
        unique case (rel)
            pred_pkg::REL_EQ:  hit = eq_w;
            pred_pkg::REL_NE:  hit = !eq_w;
            pred_pkg::REL_SLT: hit = slt_w;
            pred_pkg::REL_SLE: hit = slt_w || eq_w;
            pred_pkg::REL_SGT: hit = !(slt_w || eq_w);
            pred_pkg::REL_SGE: hit = !slt_w;
            pred_pkg::REL_ULT: hit = ult_w;
            pred_pkg::REL_UGE: hit = !ult_w;
            default:           hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pred_slot_gen.sv
module pred_slot_gen #(
    parameter int NUM_PREDS = 16,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_PREDS),
    localparam int PAIR_W   = IDX_W - 1
) (
    input  logic                 slot_valid,
    input  pred_pkg::rel_e       rel,
    input  logic [DATA_W-1:0]    opnd_a,
    input  logic [DATA_W-1:0]    opnd_b,
    input  logic [PAIR_W-1:0]    pair,
    input  logic [IDX_W-1:0]     guard,
    input  logic [NUM_PREDS-1:0] preds_q,
    output logic [NUM_PREDS-1:0] wr_mask,
    output logic [NUM_PREDS-1:0] wr_val
);
    logic rel_hit;
    logic guard_ok;

    pred_rel_eval #(.DATA_W(DATA_W)) u_rel (
        .rel    (rel),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .hit    (rel_hit)
    );

    // guard reads registered state: no same-cycle bypass
    assign guard_ok = preds_q[guard];

    always_comb begin
        for (int i = 0; i < NUM_PREDS; i++) begin
            wr_mask[i] = slot_valid && (i != 0) && (PAIR_W'(i >> 1) == pair);
            wr_val[i]  = guard_ok && ((i % 2 == 1) ? !rel_hit : rel_hit);
        end
    end
endmodule

// File: rtl/pred_query_port.sv
module pred_query_port #(
    parameter int NUM_PREDS = 16,
    localparam int IDX_W    = $clog2(NUM_PREDS)
) (
    input  logic                 op_valid,
    input  logic [IDX_W-1:0]     op_idx,
    input  logic [NUM_PREDS-1:0] preds_q,
    output logic                 commit
);
    assign commit = op_valid && preds_q[op_idx];
endmodule

// File: rtl/pred_file_top.sv
module pred_file_top #(
    parameter int NUM_PREDS = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_SLOTS = 2,
    parameter int NUM_QUERY = 3
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [NUM_SLOTS-1:0]                        cmp_valid,
    input  logic [NUM_SLOTS-1:0][2:0]                   cmp_op,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]            cmp_src_a,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]            cmp_src_b,
    input  logic [NUM_SLOTS-1:0][$clog2(NUM_PREDS)-2:0] cmp_pair,
    input  logic [NUM_SLOTS-1:0][$clog2(NUM_PREDS)-1:0] cmp_guard,
    input  logic [NUM_QUERY-1:0]                        qry_valid,
    input  logic [NUM_QUERY-1:0][$clog2(NUM_PREDS)-1:0] qry_idx,
    output logic [NUM_QUERY-1:0]                        qry_commit,
    output logic [NUM_PREDS-1:0]                        pred_vec
);
    localparam logic [NUM_PREDS-1:0] RESET_PREDS = NUM_PREDS'(1);

    typedef struct packed {
        logic [NUM_PREDS-1:0] preds;
    } pred_state_t;

    pred_state_t state_d, state_q;

    logic [NUM_SLOTS-1:0][NUM_PREDS-1:0] slot_mask;
    logic [NUM_SLOTS-1:0][NUM_PREDS-1:0] slot_val;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        pred_slot_gen #(
            .NUM_PREDS (NUM_PREDS),
            .DATA_W    (DATA_W)
        ) u_slot (
            .slot_valid (cmp_valid[s]),
            .rel        (pred_pkg::rel_e'(cmp_op[s])),
            .opnd_a     (cmp_src_a[s]),
            .opnd_b     (cmp_src_b[s]),
            .pair       (cmp_pair[s]),
            .guard      (cmp_guard[s]),
            .preds_q    (state_q.preds),
            .wr_mask    (slot_mask[s]),
            .wr_val     (slot_val[s])
        );
    end

    for (genvar k = 0; k < NUM_QUERY; k++) begin : g_qry
        pred_query_port #(.NUM_PREDS(NUM_PREDS)) u_qry (
            .op_valid (qry_valid[k]),
            .op_idx   (qry_idx[k]),
            .preds_q  (state_q.preds),
            .commit   (qry_commit[k])
        );
    end

    // later slots overwrite earlier ones: higher slot wins per flag
    always_comb begin
        state_d = state_q;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            state_d.preds = (state_d.preds & ~slot_mask[s])
                          | (slot_val[s] & slot_mask[s]);
        end
        state_d.preds[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.preds <= RESET_PREDS;
        end else begin
            state_q <= state_d;
        end
    end

    assign pred_vec = state_q.preds;
endmodule

// File: rtl/pred_file_chk.sv
module pred_file_chk #(
    parameter int NUM_PREDS = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_SLOTS = 2,
    parameter int NUM_QUERY = 3,
    localparam int IDX_W    = $clog2(NUM_PREDS),
    localparam int PAIR_W   = IDX_W - 1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_SLOTS-1:0]             cmp_valid,
    input logic [NUM_SLOTS-1:0][PAIR_W-1:0] cmp_pair,
    input logic [NUM_SLOTS-1:0][IDX_W-1:0]  cmp_guard,
    input logic [NUM_QUERY-1:0]             qry_valid,
    input logic [NUM_QUERY-1:0][IDX_W-1:0]  qry_idx,
    input logic [NUM_QUERY-1:0]             qry_commit,
    input logic [NUM_PREDS-1:0]             pred_vec
);
    localparam int TOP = NUM_SLOTS - 1;

    assert_flag0_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_vec[0]);

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|cmp_valid) |=> $stable(pred_vec));

    assert_pair_complement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid[TOP] && cmp_pair[TOP] != '0)
        |=> !(pred_vec[{$past(cmp_pair[TOP]), 1'b0}] && pred_vec[{$past(cmp_pair[TOP]), 1'b1}]));

    assert_guard_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid[TOP] && cmp_pair[TOP] != '0 && !pred_vec[cmp_guard[TOP]])
        |=> (!pred_vec[{$past(cmp_pair[TOP]), 1'b0}] && !pred_vec[{$past(cmp_pair[TOP]), 1'b1}]));

    for (genvar k = 0; k < NUM_QUERY; k++) begin : g_q
        assert_commit_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
            qry_commit[k] |-> (qry_valid[k] && pred_vec[qry_idx[k]]));
    end
endmodule

bind pred_file_top pred_file_chk #(
    .NUM_PREDS (NUM_PREDS),
    .DATA_W    (DATA_W),
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_QUERY (NUM_QUERY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_valid  (cmp_valid),
    .cmp_pair   (cmp_pair),
    .cmp_guard  (cmp_guard),
    .qry_valid  (qry_valid),
    .qry_idx    (qry_idx),
    .qry_commit (qry_commit),
    .pred_vec   (pred_vec)
);

// File: tb/pred_file_top_tb.sv
`timescale 1ns/1ps
module pred_file_top_tb;
    localparam int NP = 16;
    localparam int DW = 32;
    localparam int NS = 2;
    localparam int NQ = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]         cmp_valid = '0;
    logic [NS-1:0][2:0]    cmp_op    = '0;
    logic [NS-1:0][DW-1:0] cmp_src_a = '0;
    logic [NS-1:0][DW-1:0] cmp_src_b = '0;
    logic [NS-1:0][2:0]    cmp_pair  = '0;
    logic [NS-1:0][3:0]    cmp_guard = '0;
    logic [NQ-1:0]         qry_valid = '0;
    logic [NQ-1:0][3:0]    qry_idx   = '0;
    logic [NQ-1:0]         qry_commit;
    logic [NP-1:0]         pred_vec;

    int checks = 0;
    int failures = 0;
    logic [NP-1:0] exp_q = 16'h0001;

    always #2.5 clk = ~clk;

    pred_file_top #(.NUM_PREDS(NP), .DATA_W(DW), .NUM_SLOTS(NS), .NUM_QUERY(NQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
        .cmp_src_a(cmp_src_a), .cmp_src_b(cmp_src_b), .cmp_pair(cmp_pair),
        .cmp_guard(cmp_guard), .qry_valid(qry_valid), .qry_idx(qry_idx),
        .qry_commit(qry_commit), .pred_vec(pred_vec)
    );

    function automatic logic rel_fn(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return $signed(a) <  $signed(b);
            3'd3: return $signed(a) <= $signed(b);
            3'd4: return $signed(a) >  $signed(b);
            3'd5: return $signed(a) >= $signed(b);
            3'd6: return a <  b;
            default: return a >= b;
        endcase
    endfunction

    function automatic logic [NP-1:0] model_next(input logic [NP-1:0] cur);
        logic [NP-1:0] nxt = cur;
        for (int s = 0; s < NS; s++) begin
            if (cmp_valid[s]) begin
                logic r = rel_fn(cmp_op[s], cmp_src_a[s], cmp_src_b[s]);
                logic g = cur[cmp_guard[s]];
                nxt[{cmp_pair[s], 1'b0}] = g & r;
                nxt[{cmp_pair[s], 1'b1}] = g & ~r;
            end
        end
        nxt[0] = 1'b1;
        return nxt;
    endfunction

    function automatic logic [DW-1:0] pick_opnd();
        case ($urandom_range(0, 5))
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            default: return $urandom_range(0, 3);
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string req);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic settle(input string req);
        #1;
        chk(32'(pred_vec), 32'(exp_q), req);
        for (int k = 0; k < NQ; k++)
            chk(32'(qry_commit[k]), 32'(qry_valid[k] & exp_q[qry_idx[k]]), "R8");
    endtask

    task automatic step();
        logic [NP-1:0] nxt = model_next(exp_q);
        @(posedge clk);
        exp_q = nxt;
        @(negedge clk);
    endtask

    task automatic set_cmp(input int s, input logic [2:0] op, input logic [DW-1:0] a,
                           input logic [DW-1:0] b, input logic [2:0] p, input logic [3:0] g);
        cmp_valid[s] = 1'b1; cmp_op[s] = op; cmp_src_a[s] = a;
        cmp_src_b[s] = b; cmp_pair[s] = p; cmp_guard[s] = g;
    endtask

    task automatic idle();
        cmp_valid = '0;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        settle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        settle("R1");
        chk(32'(pred_vec), 32'h0001, "R1");

        // R3 / R4: signed vs unsigned boundary, pair 3
        set_cmp(1, 3'd2, 32'h8000_0000, 32'h1, 3'd3, 4'd0);
        qry_valid = 3'b001; qry_idx[0] = 4'd6;
        settle("R6");          // old value before the write
        chk(32'(qry_commit[0]), 32'h0, "R6");
        step(); idle();
        settle("R4");
        chk(32'(pred_vec[7:6]), 32'h1, "R3");
        chk(32'(qry_commit[0]), 32'h1, "R6");

        set_cmp(1, 3'd6, 32'h8000_0000, 32'h1, 3'd3, 4'd0);
        step(); idle();
        settle("R3");
        chk(32'(pred_vec[7:6]), 32'h2, "R3");

        // R3 equal operands on le / ge
        set_cmp(0, 3'd3, 32'h5, 32'h5, 3'd1, 4'd0);
        set_cmp(1, 3'd5, 32'h5, 32'h5, 3'd2, 4'd0);
        step(); idle();
        settle("R3");
        chk(32'(pred_vec[5:2]), 32'h5, "R3");

        // R2: pair 0 write ignored by flag 0
        set_cmp(1, 3'd1, 32'h0, 32'h0, 3'd0, 4'd0);
        step(); idle();
        settle("R2");
        chk(32'(pred_vec[1:0]), 32'h3, "R2");

        // R5: guard flag 6 is clear (ult above gave pred6=0)
        set_cmp(1, 3'd0, 32'h9, 32'h9, 3'd5, 4'd6);
        step(); idle();
        settle("R5");
        chk(32'(pred_vec[11:10]), 32'h0, "R5");
        // guard flag 7 set
        set_cmp(1, 3'd0, 32'h9, 32'h9, 3'd5, 4'd7);
        step(); idle();
        settle("R5");
        chk(32'(pred_vec[11:10]), 32'h1, "R5");

        // R7: both slots write pair 4, slot 1 wins
        set_cmp(0, 3'd0, 32'h1, 32'h1, 3'd4, 4'd0);
        set_cmp(1, 3'd1, 32'h1, 32'h1, 3'd4, 4'd0);
        step(); idle();
        settle("R7");
        chk(32'(pred_vec[9:8]), 32'h2, "R7");

        // R9: invalid slot with live data
        cmp_valid = '0; cmp_op[1] = 3'd0; cmp_src_a[1] = 0; cmp_src_b[1] = 0; cmp_pair[1] = 3'd4;
        step();
        settle("R9");
        chk(32'(pred_vec[9:8]), 32'h2, "R9");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            for (int s = 0; s < NS; s++) begin
                cmp_valid[s] = ($urandom_range(0, 3) != 0);
                cmp_op[s]    = 3'($urandom_range(0, 7));
                cmp_src_a[s] = pick_opnd();
                cmp_src_b[s] = pick_opnd();
                cmp_pair[s]  = 3'($urandom_range(0, 7));
                cmp_guard[s] = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
            end
            if ($urandom_range(0, 3) == 0) cmp_pair[1] = cmp_pair[0];
            for (int k = 0; k < NQ; k++) begin
                qry_valid[k] = 1'($urandom_range(0, 1));
                qry_idx[k]   = 4'($urandom_range(0, 15));
            end
            settle("R4_R5_R7 random");
            step();
        end
        idle();
        qry_valid = '0;
        settle("R9");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule